// File: doc/BRIEF.md
# Vector unzip permute unit

This unit takes one 32-bit vector unzip instruction word and two source vector operands, and produces the destination vector in the next cycle. From the word it extracts the length bit, the element-size field, the even/odd selector and the destination register index. It also checks the fixed opcode bits and the reserved size/length combination.

The two sources are joined, with the second source in the upper part and the first source in the lower part. The result then takes every other element of the joined value, starting at element 0 (even) or element 1 (odd). The picks from the first source land in the lower half of the result in order, and the picks from the second source land in the upper half in order. No data value is altered and no flags are produced.

The result, the register index, a write enable and an illegal-encoding flag are registered outputs. A surrounding pipeline uses the write enable to commit the result to its register file.

Top module: `uzp_unit`

## Requirements
- R1: A legal word presented with `valid_i` high at a rising edge gives `we_o`=1 and `illegal_o`=0 after that edge, with `rd_o` equal to instruction bits [4:0].
- R2: A word is illegal unless bit 31=0, bits [29:24]=001110, bit 21=0, bit 15=0 and bits [13:10]=0110. Such a word presented with `valid_i` gives `illegal_o`=1, `we_o`=0 and `result_o`=0 after the edge.
- R3: Size field bits [23:22]=11 with length bit 30=0 is reserved. It gives `illegal_o`=1, `we_o`=0 and `result_o`=0.
- R4: With bit 30=1 (128-bit length), the joined value is {src_b_i, src_a_i}. Result element e equals joined element 2e+p for e from 0 to 128/EW-1.
- R5: With bit 30=0 (64-bit length), the joined value is {src_b_i[63:0], src_a_i[63:0]}. Result element e equals joined element 2e+p for e from 0 to 64/EW-1, and `result_o[127:64]` is 0.
- R6: Instruction bit 14 gives p: 0 selects even elements (starting at 0), and 1 selects odd elements (starting at 1).
- R7: Size field [23:22] sets the element width EW: 00=8, 01=16, 10=32 and 11=64 bits.
- R8: A rising edge with `valid_i` low gives `we_o`=0 and `illegal_o`=0, and leaves `result_o` and `rd_o` unchanged.
- R9: Synchronous active-high `rst` clears `result_o`, `rd_o`, `we_o` and `illegal_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction word and operands are valid this cycle |
| instr_i | input | 32 | Unzip instruction word |
| src_a_i | input | 128 | First source operand (lower part of the joined value) |
| src_b_i | input | 128 | Second source operand (upper part of the joined value) |
| result_o | output | 128 | Registered destination vector |
| rd_o | output | 5 | Registered destination register index |
| we_o | output | 1 | Write enable, one cycle after an accepted legal word |
| illegal_o | output | 1 | Illegal encoding flag, one cycle after an offending word |

## Verification
The permutation is tried on every element width, in both lengths and with both selector values. Each source carries distinct byte values in every lane, so a result taken from the wrong lane, the wrong source or the wrong half shows up. Two hand-worked byte patterns separate the even pick from the odd pick exactly. Single-bit corruptions of each fixed opcode field, and the reserved size/length pair, tell a decode that checks every fixed bit apart from one that misses some. Idle cycles after a transaction show whether the outputs hold or get overwritten.

// File: rtl/uzp_pkg.sv
package uzp_pkg;
  localparam int IW   = 32;
  localparam int RIDX = 5;

  localparam logic [IW-1:0] FIX_MASK = 32'hBF20_BC00;
  localparam logic [IW-1:0] FIX_VAL  = 32'h0E00_1800;

  typedef enum logic [1:0] {
    ESZ_8  = 2'b00,
    ESZ_16 = 2'b01,
    ESZ_32 = 2'b10,
    ESZ_64 = 2'b11
  } esize_e;

  typedef struct packed {
    logic            wide;
    esize_e          esz;
    logic            odd;
    logic [RIDX-1:0] rd;
    logic            legal;
  } dec_t;
endpackage

// File: rtl/uzp_decode.sv
module uzp_decode
  import uzp_pkg::*;
(
  input  logic [IW-1:0] instr_i,
  output dec_t          dec_o
);
  logic fixed_ok;
  logic reserved;
  logic unused_idx;

  assign fixed_ok   = (instr_i & FIX_MASK) == FIX_VAL;
  assign reserved   = (instr_i[23:22] == ESZ_64) && !instr_i[30];
  assign unused_idx = ^{instr_i[20:16], instr_i[9:5]};

  always_comb begin
    dec_o.wide  = instr_i[30];
    dec_o.esz   = esize_e'(instr_i[23:22]);
    dec_o.odd   = instr_i[14];
    dec_o.rd    = instr_i[RIDX-1:0];
    dec_o.legal = fixed_ok && !reserved;
  end
endmodule

// File: rtl/uzp_permute.sv
module uzp_permute
  import uzp_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic [VLEN-1:0] a_i,
  input  logic [VLEN-1:0] b_i,
  input  logic            wide_i,
  input  esize_e          esz_i,
  input  logic            odd_i,
  output logic [VLEN-1:0] res_o
);
  localparam int HLEN = VLEN / 2;
  localparam int NSZ  = 4;

  logic [2*VLEN-1:0] join_full;
  logic [VLEN-1:0]   join_half;
  logic [VLEN-1:0]   full_res [NSZ];
  logic [VLEN-1:0]   half_res [NSZ];

  assign join_full = {b_i, a_i};
  assign join_half = {b_i[HLEN-1:0], a_i[HLEN-1:0]};

  for (genvar gs = 0; gs < NSZ; gs++) begin : g_sz
    localparam int EW = 8 << gs;
    localparam int NF = VLEN / EW;
    localparam int NH = HLEN / EW;
    logic [VLEN-1:0] f_r;
    logic [VLEN-1:0] h_r;

    always_comb begin
      f_r = '0;
      h_r = '0;
      for (int e = 0; e < NF; e++) begin
        f_r[e*EW +: EW] = odd_i ? join_full[(2*e+1)*EW +: EW]
                                : join_full[(2*e)*EW +: EW];
      end
      for (int e = 0; e < NH; e++) begin
        h_r[e*EW +: EW] = odd_i ? join_half[(2*e+1)*EW +: EW]
                                : join_half[(2*e)*EW +: EW];
      end
    end

    assign full_res[gs] = f_r;
    assign half_res[gs] = h_r;
  end

  assign res_o = wide_i ? full_res[esz_i] : half_res[esz_i];
endmodule

// File: rtl/uzp_unit.sv
module uzp_unit
  import uzp_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [VLEN-1:0] src_a_i,
  input  logic [VLEN-1:0] src_b_i,
  output logic [VLEN-1:0] result_o,
  output logic [4:0]      rd_o,
  output logic            we_o,
  output logic            illegal_o
);
  dec_t            dec;
  logic [VLEN-1:0] perm;

  uzp_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  uzp_permute #(.VLEN(VLEN)) u_perm (
    .a_i    (src_a_i),
    .b_i    (src_b_i),
    .wide_i (dec.wide),
    .esz_i  (dec.esz),
    .odd_i  (dec.odd),
    .res_o  (perm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      rd_o      <= '0;
      we_o      <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      we_o      <= valid_i && dec.legal;
      illegal_o <= valid_i && !dec.legal;
      if (valid_i) begin
        result_o <= dec.legal ? perm : '0;
        rd_o     <= dec.rd;
      end
    end
  end
endmodule

// File: rtl/uzp_unit_chk.sv
module uzp_unit_chk (
  input logic         clk,
  input logic         rst,
  input logic         valid_i,
  input logic [31:0]  instr_i,
  input logic [127:0] result_o,
  input logic [4:0]   rd_o,
  input logic         we_o,
  input logic         illegal_o
);
  // R1
  p_we_rd_r1: assert property (@(posedge clk) disable iff (rst)
    we_o |-> (rd_o == $past(instr_i[4:0])) && !illegal_o);

  // R2
  p_illegal_zero_r2: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (result_o == '0) && !we_o);

  // R3
  p_reserved_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_i && instr_i[23:22] == 2'b11 && !instr_i[30]) |=> illegal_o && !we_o);

  // R5
  p_half_upper_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !instr_i[30]) |=> result_o[127:64] == '0);

  // R8
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !we_o && !illegal_o && $stable(result_o) && $stable(rd_o));
endmodule

bind uzp_unit uzp_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid_i   (valid_i),
  .instr_i   (instr_i),
  .result_o  (result_o),
  .rd_o      (rd_o),
  .we_o      (we_o),
  .illegal_o (illegal_o)
);

// File: tb/tb_uzp_unit.sv
module tb_uzp_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         valid_i;
  logic [31:0]  instr_i;
  logic [127:0] src_a_i;
  logic [127:0] src_b_i;
  logic [127:0] result_o;
  logic [4:0]   rd_o;
  logic         we_o;
  logic         illegal_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  uzp_unit dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .result_o(result_o),
    .rd_o(rd_o), .we_o(we_o), .illegal_o(illegal_o)
  );

  localparam int NV = 15;
  // {instruction word, expected legal}
  localparam logic [32:0] VEC [NV] = '{
    {32'h4E001803, 1'b1},  // wide, 8-bit, even
    {32'h4E405805, 1'b1},  // wide, 16-bit, odd
    {32'h4E8018A7, 1'b1},  // wide, 32-bit, even
    {32'h4EC05BFF, 1'b1},  // wide, 64-bit, odd
    {32'h0E001801, 1'b1},  // narrow, 8-bit, even
    {32'h0E405802, 1'b1},  // narrow, 16-bit, odd
    {32'h0E801804, 1'b1},  // narrow, 32-bit, even
    {32'h0E805806, 1'b1},  // narrow, 32-bit, odd
    {32'h4E1F1809, 1'b1},  // wide, 8-bit, Rm=31
    {32'h0EC01808, 1'b0},  // reserved narrow 64-bit
    {32'hCE001800, 1'b0},  // bit 31 set
    {32'h4E201800, 1'b0},  // bit 21 set
    {32'h4E009800, 1'b0},  // bit 15 set
    {32'h4E001C00, 1'b0},  // bit 10 set
    {32'h4F001800, 1'b0}   // bit 24 set
  };

  function automatic logic [127:0] model(input logic [31:0] w,
                                         input logic [127:0] a,
                                         input logic [127:0] b);
    logic [255:0] j;
    logic [127:0] r;
    int ew, nres, p;
    ew   = 8 << w[23:22];
    nres = (w[30] ? 128 : 64) / ew;
    p    = w[14] ? 1 : 0;
    j    = w[30] ? {b, a} : {128'd0, b[63:0], a[63:0]};
    r    = '0;
    for (int e = 0; e < nres; e++)
      for (int k = 0; k < ew; k++)
        r[e*ew + k] = j[(2*e + p)*ew + k];
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [127:0] a,
                       input logic [127:0] b);
    @(negedge clk);
    valid_i = 1'b1; instr_i = w; src_a_i = a; src_b_i = b;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] a, b, exp, keep;
    logic [4:0]   keep_rd;
    rst = 1'b1; valid_i = 1'b0; instr_i = '0; src_a_i = '0; src_b_i = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 result", result_o, '0);
    check("R9 flags", {123'd0, rd_o, we_o, illegal_o}, '0);
    rst = 1'b0;

    // Table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < 16; k++) begin
        a[k*8 +: 8] = 8'(k + 16*i);
        b[k*8 +: 8] = 8'(8'h80 + k + 7*i);
      end
      issue(VEC[i][32:1], a, b);
      exp = VEC[i][0] ? model(VEC[i][32:1], a, b) : '0;
      check("R4 R5 R6 R7 result", result_o, exp);
      check("R1 R2 R3 flags", {126'd0, we_o, illegal_o},
            {126'd0, VEC[i][0], !VEC[i][0]});
      if (VEC[i][0]) check("R1 rd", {123'd0, rd_o}, {123'd0, VEC[i][5:1]});
    end

    // Hand-worked byte patterns: byte k of a = k, byte k of b = 0x10+k
    for (int k = 0; k < 16; k++) begin
      a[k*8 +: 8] = 8'(k);
      b[k*8 +: 8] = 8'(16 + k);
    end
    issue(32'h4E001800, a, b);
    check("R4 even bytes", result_o, 128'h1E1C1A18161412100E0C0A0806040200);
    issue(32'h4E005800, a, b);
    check("R6 odd bytes", result_o, 128'h1F1D1B19171513110F0D0B0907050301);
    issue(32'h0E001800, a, b);
    check("R5 narrow even bytes", result_o, 128'h0000000000000000_16141210_06040200);
    issue(32'h4EC01800, a, b);
    check("R7 wide 64-bit even", result_o, {b[63:0], a[63:0]});

    // R8: idle cycles hold the outputs
    issue(32'h4E80181B, a, b);
    keep = result_o; keep_rd = rd_o;
    repeat (3) @(negedge clk);
    check("R8 hold result", result_o, keep);
    check("R8 hold rd/flags", {121'd0, rd_o, we_o, illegal_o},
          {121'd0, keep_rd, 2'b00});

    // R9: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R9 re-reset", result_o, '0);
    rst = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule